// File: doc/BRIEF.md
# Synchronous Buck Gate Sequencer

This block turns a digital on-time command into the two gate enables of a synchronous step-down stage. A free-running counter defines the switching period. At each period boundary the block latches the on-time and samples two fast window flags from the feedback path. It then produces a high-side pulse followed by a low-side pulse. A guaranteed idle gap separates the two pulses, so the gates never conduct together. The on-time is capped at a fixed fraction of the period, which leaves off-time in every cycle.

The two window flags bypass the normal command. A feedback-too-low flag drives the stage to the on-time cap, and a feedback-too-high flag forces zero on-time. Each flag must hold for consecutive boundary samples before it acts. The low flag is ignored while soft start runs. After reset or after any driver shutdown, the low-side gate stays off until the high-side gate has pulsed once. This keeps the output from being pulled below its start level. The on-time command and flags are plain levels with no handshake. The command is read only at the boundary and may change at any time.

Top module: `buck_gate_seq`

## Requirements
- R1: While reset is asserted and after its release, both gates are low until the first commanded high-side pulse.
- R2: The two gates are never high in the same cycle, and a rising gate is preceded by at least DEAD_CYC consecutive cycles with both gates low.
- R3: The period counter starts at 0 on the first clock after reset release and wraps at PERIOD_CYC-1. The on-time N latched at the wrap edge applies to the next period. In steady state with the low side armed, the high gate is high for N-DEAD_CYC-1 cycles (phases DEAD_CYC+2 to N). The low gate is high for PERIOD_CYC-N-DEAD_CYC-1 cycles of each period.
- R4: An on-time command above MAX_ON = PERIOD_CYC*MAX_PCT/100 is treated as MAX_ON.
- R5: A command of zero produces no high-side pulse. An armed low side then stays high for the whole period.
- R6: After reset, or after drv_off or kill has been asserted, the low gate stays low until the high gate has gone high once.
- R7: One cycle after drv_off or kill is seen high, both gates are low. They stay low while either input is high.
- R8: fb_high, sampled high at PERSIST consecutive wrap edges, forces zero on-time from the period that follows the next wrap. A single high sample has no effect. fb_high takes priority over fb_low.
- R9: fb_low, sampled high at PERSIST consecutive wrap edges, forces the on-time to MAX_ON with the same latency as R8. When fb_low falls, the override ends with the same latency.
- R10: While soft_start is high, fb_low is disregarded and its persistence count is cleared.
- R11: In steady state the high gate rises at period phase DEAD_CYC+2, one rise per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| duty_cmd | input | CNT_W | High-side on-time request in clock cycles |
| soft_start | input | 1 | Soft start in progress; blocks the low-feedback override |
| fb_low | input | 1 | Feedback below the lower window limit |
| fb_high | input | 1 | Feedback above the upper window limit |
| drv_off | input | 1 | Driver disable (thermal), both gates off |
| kill | input | 1 | Fault shutdown, both gates off |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |

## Verification
The override persistence is the hardest behaviour to reach from the ports. Its effect appears only two period boundaries after the flag first settles, and a single-period pulse must leave no trace. The stimulus changes the flags mid-period and measures pulse widths per period against a phase counter kept in the bench. It holds a flag across exactly one boundary, then across several. The arming rule is reached by disabling the drivers while the low side is on and re-enabling with a zero command. A low gate that rises then shows up as nonzero low-side width.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

  typedef enum int unsigned {
    OVR_LOW  = 0,
    OVR_HIGH = 1
  } ovr_idx_e;

  localparam int unsigned N_OVR = 2;

  // Limit a requested on-time to the ceiling.
  function automatic int unsigned clamp_on(input int unsigned req, input int unsigned ceil_v);
    return (req > ceil_v) ? ceil_v : req;
  endfunction

endpackage

// File: rtl/bsq_period_ctr.sv
module bsq_period_ctr #(
  parameter int unsigned PERIOD_CYC = 167,
  localparam int unsigned CNT_W     = $clog2(PERIOD_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] phase,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);

  assign wrap = (phase == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase <= '0;
    else if (wrap) phase <= '0;
    else           phase <= phase + 1'b1;
  end
endmodule

// File: rtl/bsq_persist.sv
module bsq_persist #(
  parameter int unsigned PERSIST = 2,
  localparam int unsigned PW     = $clog2(PERSIST + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample,
  input  logic flag,
  input  logic clear,
  output logic engaged
);
  localparam logic [PW-1:0] FULL = PW'(PERSIST);
  logic [PW-1:0] run_q;

  assign engaged = (run_q == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (clear)  run_q <= '0;
    else if (sample) begin
      if (!flag)             run_q <= '0;
      else if (run_q != FULL) run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/bsq_gate_drv.sv
module bsq_gate_drv #(
  parameter int unsigned DEAD_CYC = 5,
  localparam int unsigned GW      = $clog2(DEAD_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic hs_req,
  output logic gate_hi,
  output logic gate_lo
);
  localparam logic [GW-1:0] GAP_LOAD = GW'(DEAD_CYC);
  logic [GW-1:0] gap_q;
  logic          armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
      gap_q   <= GAP_LOAD;
      armed_q <= 1'b0;
    end else if (!run) begin
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
      gap_q   <= GAP_LOAD;
      armed_q <= 1'b0;
    end else begin
      if (gate_hi) armed_q <= 1'b1;
      if (gate_hi && !hs_req) begin
        gate_hi <= 1'b0;
        gap_q   <= GAP_LOAD;
      end else if (gate_lo && hs_req) begin
        gate_lo <= 1'b0;
        gap_q   <= GAP_LOAD;
      end else if (gap_q != '0) begin
        gap_q <= gap_q - 1'b1;
      end else if (hs_req && !gate_lo) begin
        gate_hi <= 1'b1;
      end else if (!hs_req && armed_q && !gate_hi) begin
        gate_lo <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq #(
  parameter int unsigned PERIOD_CYC = 167,
  parameter int unsigned DEAD_CYC   = 5,
  parameter int unsigned MAX_PCT    = 90,
  parameter int unsigned PERSIST    = 2,
  localparam int unsigned CNT_W     = $clog2(PERIOD_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] duty_cmd,
  input  logic             soft_start,
  input  logic             fb_low,
  input  logic             fb_high,
  input  logic             drv_off,
  input  logic             kill,
  output logic             gate_hi,
  output logic             gate_lo
);
  import bsq_pkg::*;

  localparam int unsigned MAX_ON = (PERIOD_CYC * MAX_PCT) / 100;

  logic [CNT_W-1:0] phase;
  logic             wrap;
  logic [CNT_W-1:0] on_len_q;
  logic [N_OVR-1:0] ovr_flag, ovr_clr, ovr_eng;
  logic             run;

  bsq_period_ctr #(.PERIOD_CYC(PERIOD_CYC)) u_ctr (
    .clk(clk), .rst_n(rst_n), .phase(phase), .wrap(wrap)
  );

  assign ovr_flag[OVR_LOW]  = fb_low;
  assign ovr_clr[OVR_LOW]   = soft_start;
  assign ovr_flag[OVR_HIGH] = fb_high;
  assign ovr_clr[OVR_HIGH]  = 1'b0;

  for (genvar g = 0; g < N_OVR; g++) begin : g_ovr
    bsq_persist #(.PERSIST(PERSIST)) u_persist (
      .clk(clk), .rst_n(rst_n), .sample(wrap),
      .flag(ovr_flag[g]), .clear(ovr_clr[g]), .engaged(ovr_eng[g])
    );
  end

  // On-time for the coming period, fixed at the wrap edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) on_len_q <= '0;
    else if (wrap) begin
      if (ovr_eng[OVR_HIGH])     on_len_q <= '0;
      else if (ovr_eng[OVR_LOW]) on_len_q <= CNT_W'(MAX_ON);
      else on_len_q <= CNT_W'(clamp_on(int'(duty_cmd), MAX_ON));
    end
  end

  assign run = !drv_off && !kill;

  bsq_gate_drv #(.DEAD_CYC(DEAD_CYC)) u_drv (
    .clk(clk), .rst_n(rst_n), .run(run),
    .hs_req(phase < on_len_q),
    .gate_hi(gate_hi), .gate_lo(gate_lo)
  );
endmodule

// File: rtl/buck_gate_seq_chk.sv
module buck_gate_seq_chk #(
  parameter int unsigned PERIOD_CYC = 167,
  parameter int unsigned DEAD_CYC   = 5,
  parameter int unsigned MAX_PCT    = 90,
  localparam int unsigned CNT_W     = $clog2(PERIOD_CYC + 1)
) (
  input logic clk,
  input logic rst_n,
  input logic drv_off,
  input logic kill,
  input logic gate_hi,
  input logic gate_lo
);
  localparam int unsigned MAX_ON = (PERIOD_CYC * MAX_PCT) / 100;
  localparam int unsigned QW     = $clog2(DEAD_CYC + 2);

  logic [QW-1:0]    quiet_q;
  logic [CNT_W-1:0] hi_run_q;
  logic             seen_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_q   <= '0;
      hi_run_q  <= '0;
      seen_hi_q <= 1'b0;
    end else begin
      if (gate_hi || gate_lo)          quiet_q <= '0;
      else if (quiet_q != QW'(DEAD_CYC)) quiet_q <= quiet_q + 1'b1;
      hi_run_q <= gate_hi ? hi_run_q + 1'b1 : '0;
      if (drv_off || kill) seen_hi_q <= 1'b0;
      else if (gate_hi)    seen_hi_q <= 1'b1;
    end
  end

  p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));
  p_gap_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hi) |-> (quiet_q >= QW'(DEAD_CYC)));
  p_gap_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_lo) |-> (quiet_q >= QW'(DEAD_CYC)));
  p_hi_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hi_run_q <= CNT_W'(MAX_ON));
  p_arm_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_lo) |-> seen_hi_q);
  p_shutoff_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_off || kill) |=> (!gate_hi && !gate_lo));
endmodule

bind buck_gate_seq buck_gate_seq_chk #(
  .PERIOD_CYC(PERIOD_CYC), .DEAD_CYC(DEAD_CYC), .MAX_PCT(MAX_PCT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .drv_off(drv_off), .kill(kill),
  .gate_hi(gate_hi), .gate_lo(gate_lo)
);

// File: tb/buck_gate_seq_test.sv
module buck_gate_seq_test;
  localparam int P     = 40;
  localparam int D     = 2;
  localparam int MAXON = 36;
  localparam int CW    = $clog2(P + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0] duty_cmd = '0;
  logic soft_start = 0, fb_low = 0, fb_high = 0, drv_off = 0, kill = 0;
  logic gate_hi, gate_lo;

  int n_chk = 0, n_fail = 0;
  int ph = 0, hs_acc = 0, ls_acc = 0, hs_w = 0, ls_w = 0, rise_ph = -1, rise_acc = -1;
  logic hi_d = 0;
  bit done = 0;

  buck_gate_seq #(.PERIOD_CYC(P), .DEAD_CYC(D), .MAX_PCT(90), .PERSIST(2)) uut (
    .clk(clk), .rst_n(rst_n), .duty_cmd(duty_cmd), .soft_start(soft_start),
    .fb_low(fb_low), .fb_high(fb_high), .drv_off(drv_off), .kill(kill),
    .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  always #10 clk = ~clk;

  // Bench phase: mirrors the period phase defined in R3.
  always @(posedge clk) ph <= !rst_n ? 0 : (ph == P - 1 ? 0 : ph + 1);

  always @(negedge clk) if (rst_n) begin
    if (gate_hi) hs_acc++;
    if (gate_lo) ls_acc++;
    if (gate_hi && !hi_d) rise_acc = ph;
    hi_d = gate_hi;
    if (ph == P - 1) begin
      hs_w = hs_acc; ls_w = ls_acc; rise_ph = rise_acc;
      hs_acc = 0; ls_acc = 0; rise_acc = -1;
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_periods(int k);
    for (int i = 0; i < k; i++) begin
      do @(negedge clk); while (ph != P - 1);
    end
    #1;
  endtask

  task automatic t_reset;
    check("R1 hi in reset", gate_hi, 0);
    check("R1 lo in reset", gate_lo, 0);
    @(negedge clk) rst_n = 1'b1;
    wait_periods(2);
    check("R1 hi after release", hs_w, 0);
    check("R6 lo unarmed after reset", ls_w, 0);
  endtask

  task automatic t_steady;
    duty_cmd = 10; wait_periods(3);
    check("R3 hi width N=10", hs_w, 10 - D - 1);
    check("R3 lo width N=10", ls_w, P - 10 - D - 1);
    check("R11 hi rise phase", rise_ph, D + 2);
    duty_cmd = 5; wait_periods(3);
    check("R3 hi width N=5", hs_w, 5 - D - 1);
    check("R3 lo width N=5", ls_w, P - 5 - D - 1);
    duty_cmd = 50; wait_periods(3);
    check("R4 clamp hi width", hs_w, MAXON - D - 1);
    check("R4 clamp lo width", ls_w, P - MAXON - D - 1);
    duty_cmd = 0; wait_periods(3);
    check("R5 zero duty hi", hs_w, 0);
    check("R5 zero duty lo full", ls_w, P);
    duty_cmd = 10; wait_periods(3);
  endtask

  task automatic t_max_ovr;
    int mn = 1000;
    fb_high = 1; wait_periods(1); fb_high = 0;
    for (int i = 0; i < 3; i++) begin
      wait_periods(1);
      if (hs_w < mn) mn = hs_w;
    end
    check("R8 single sample ignored", mn, 10 - D - 1);
    fb_high = 1; wait_periods(4);
    check("R8 max override hi", hs_w, 0);
    check("R8 max override lo", ls_w, P);
    fb_low = 1; wait_periods(2);
    check("R8 high wins over low", hs_w, 0);
    fb_high = 0; fb_low = 0; wait_periods(3);
    check("R8 release", hs_w, 10 - D - 1);
  endtask

  task automatic t_min_ovr;
    soft_start = 1; fb_low = 1; wait_periods(4);
    check("R10 low flag ignored in soft start", hs_w, 10 - D - 1);
    soft_start = 0; wait_periods(4);
    check("R9 min override forces max", hs_w, MAXON - D - 1);
    fb_low = 0; wait_periods(3);
    check("R9 min override released", hs_w, 10 - D - 1);
  endtask

  task automatic t_disable;
    int hi_seen = 0, lo_seen = 0;
    @(negedge clk) drv_off = 1;
    @(negedge clk);
    check("R7 drv_off hi", gate_hi, 0);
    check("R7 drv_off lo", gate_lo, 0);
    duty_cmd = 0;
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      hi_seen += gate_hi; lo_seen += gate_lo;
    end
    check("R7 held off", hi_seen + lo_seen, 0);
    drv_off = 0; wait_periods(3);
    check("R6 lo unarmed after re-enable", ls_w, 0);
    duty_cmd = 10; wait_periods(3);
    check("R6 armed again", ls_w, P - 10 - D - 1);
    @(negedge clk) kill = 1;
    @(negedge clk);
    check("R7 kill gates off", gate_hi + gate_lo, 0);
    kill = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_steady;
    t_max_ovr;
    t_min_ovr;
    t_disable;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule